// File: doc/BRIEF.md
# Mode-Aware Bidirectional GPIO Port

This block is an 8-bit general-purpose I/O port placed on a simple processor register bus (address, write strobe, read strobe, write data and read data). Software controls each pin through three registers: an output latch, a direction register and a pull-up enable register. The block turns these into per-pin output value, output enable and pull-up request signals for the pad ring. It also samples the pad input levels through a synchronizer so that software can read them back.

A two-bit operating-mode input decides who owns the pins. In single-chip mode the port is ordinary GPIO under register control. In every other mode the pins carry an external data bus: the pad output value and drive come from the bus path inputs, pull-ups are forced off, and the port registers only hold their values until single-chip mode returns. Reading the data register is not a plain register read. Bits set as outputs return the latch, and bits set as inputs return the synchronized pin level.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous active-low reset, the latch, direction and pull-up registers are all 0x00. In single-chip mode the pins are then undriven with no pull-ups, and pin_out_o is 0x00.
- R2: A write to address 0xFFB6 stores the write data in the output latch. In single-chip mode pin_out_o equals the latch and pin_oe_o equals the direction register on the clock after the write.
- R3: A write to the direction address (parameter, default 0xFFB4) stores the direction register, and a read returns it. A direction bit of 1 makes that pin an output and a bit of 0 makes it an input.
- R4: A read of address 0xFFB6 returns, for each bit, the latch bit when the direction bit is 1 and the synchronized pin level when the direction bit is 0.
- R5: A pin level that is present at a rising clock edge becomes visible in read-back and on ext_pin_o after exactly two rising edges.
- R6: Address 0xFFAE holds the pull-up control register. All eight bits can be written and read back.
- R7: In single-chip mode, pin_pu_o bit i is 1 only when direction bit i is 0 and pull-up control bit i is 1. A pin that is driven never has its pull-up requested.
- R8: mode_i equal to 2'b11 selects single-chip mode. Any other value selects an expanded mode. In an expanded mode pin_out_o equals ext_data_i, every bit of pin_oe_o equals ext_drive_i, and pin_pu_o is 0x00, whatever the registers hold.
- R9: Register writes made in an expanded mode still update the registers. Their values drive the pins as soon as mode_i returns to single-chip.
- R10: A read from any address other than the three decoded ones returns 0x00, and bus_rdata_o is 0x00 whenever bus_rd_i is low. A write to an undecoded address changes no register.
- R11: When a read and a write hit the same cycle, the read returns the register contents from before that write.
- R12: ext_pin_o always presents the synchronized pin levels, in every mode, so that the external bus path can capture incoming data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Operating mode; 2'b11 selects single-chip, any other value selects expanded |
| bus_addr_i | input | 16 | Register bus address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, 0x00 when no read is active |
| pin_in_i | input | 8 | Asynchronous pad input levels |
| pin_out_o | output | 8 | Pad output values |
| pin_oe_o | output | 8 | Pad output enables, 1 means driven |
| pin_pu_o | output | 8 | Pull-up requests to the pad |
| ext_data_i | input | 8 | External bus data to drive in expanded modes |
| ext_drive_i | input | 1 | External bus drives the pins in expanded modes |
| ext_pin_o | output | 8 | Synchronized pin levels for the external bus path |

## Verification
The main overlap is a bus access that falls in the same cycle as a change that decides how the data-register read is formed. This can be a direction write, a latch write, a pin edge still inside the synchronizer, or a mode change. The bench provokes this with directed cases, such as a direction write followed by a read and a read issued together with a write to the same register. It also does so with random traffic in which mode, address, strobes and pin levels all change at once. Each cycle's read data and pin signals are judged against a bench model. The model applies writes only at the clock edge and delays pin levels by two edges, so any read that sees a write early, or a pin that arrives early or late, is reported.

// File: rtl/gpio_port_pkg.sv
// Package: shared types and helpers for the GPIO port.
// Assumes: mode encoding 2'b11 = single-chip, every other value = expanded.
package gpio_port_pkg;

    typedef enum logic [1:0] {
        MODE_EXP0   = 2'b00,
        MODE_EXP1   = 2'b01,
        MODE_EXP2   = 2'b10,
        MODE_SINGLE = 2'b11
    } port_mode_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_PULL = 2'd3
    } reg_sel_e;

    // Returns 1 when the mode code gives the pins to the register file.
    function automatic logic is_single_chip(input logic [1:0] mode);
        return mode == MODE_SINGLE;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
// Module: multi-stage synchronizer for asynchronous pad inputs.
// Assumes: each bit is sampled on its own (no multi-bit coherency needed).
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw pad level.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_i;
                end
            end else begin : g_next
                // Move the level one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
// Module: address decode plus latch, direction and pull-up registers.
// Assumes: one-cycle write strobe; writes are taken in any operating mode.
module gpio_regfile
    import gpio_port_pkg::*;
#(
    parameter int             WIDTH     = 8,
    parameter int             AW        = 16,
    parameter logic [AW-1:0]  DATA_ADDR = 16'hFFB6,
    parameter logic [AW-1:0]  DIR_ADDR  = 16'hFFB4,
    parameter logic [AW-1:0]  PULL_ADDR = 16'hFFAE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr_i,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output reg_sel_e         sel_o,
    output logic [WIDTH-1:0] data_q_o,
    output logic [WIDTH-1:0] dir_q_o,
    output logic [WIDTH-1:0] pull_q_o
);
    logic [WIDTH-1:0] data_q, dir_q, pull_q;

    // Decode the bus address into a register select.
    always_comb begin
        if (addr_i == DATA_ADDR)      sel_o = SEL_DATA;
        else if (addr_i == DIR_ADDR)  sel_o = SEL_DIR;
        else if (addr_i == PULL_ADDR) sel_o = SEL_PULL;
        else                          sel_o = SEL_NONE;
    end

    // Output latch.
    always_ff @(posedge clk) begin
        if (!rst_n)                          data_q <= '0;
        else if (wr_i && sel_o == SEL_DATA)  data_q <= wdata_i;
    end

    // Direction register, 1 = output.
    always_ff @(posedge clk) begin
        if (!rst_n)                          dir_q <= '0;
        else if (wr_i && sel_o == SEL_DIR)   dir_q <= wdata_i;
    end

    // Pull-up control register.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pull_q <= '0;
        else if (wr_i && sel_o == SEL_PULL)  pull_q <= wdata_i;
    end

    assign data_q_o = data_q;
    assign dir_q_o  = dir_q;
    assign pull_q_o = pull_q;
endmodule

// File: rtl/gpio_readback.sv
// Module: read data multiplexer with per-bit latch/pin selection.
// Assumes: combinational read in the strobe cycle, returning pre-write values.
module gpio_readback
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             rd_i,
    input  reg_sel_e         sel_i,
    input  logic [WIDTH-1:0] data_q_i,
    input  logic [WIDTH-1:0] dir_q_i,
    input  logic [WIDTH-1:0] pull_q_i,
    input  logic [WIDTH-1:0] pin_sync_i,
    output logic [WIDTH-1:0] rdata_o
);
    logic [WIDTH-1:0] port_view;

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            // Output bits report the latch, input bits report the pin.
            assign port_view[b] = dir_q_i[b] ? data_q_i[b] : pin_sync_i[b];
        end
    endgenerate

    // Pick the addressed register, zero when idle or undecoded.
    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            unique case (sel_i)
                SEL_DATA: rdata_o = port_view;
                SEL_DIR:  rdata_o = dir_q_i;
                SEL_PULL: rdata_o = pull_q_i;
                default:  rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_pin_mux.sv
// Module: pin ownership mux and pull-up gating.
// Assumes: expanded modes hand all pins to the external bus path.
module gpio_pin_mux
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [1:0]       mode_i,
    input  logic [WIDTH-1:0] data_q_i,
    input  logic [WIDTH-1:0] dir_q_i,
    input  logic [WIDTH-1:0] pull_q_i,
    input  logic [WIDTH-1:0] ext_data_i,
    input  logic             ext_drive_i,
    output logic [WIDTH-1:0] pin_out_o,
    output logic [WIDTH-1:0] pin_oe_o,
    output logic [WIDTH-1:0] pin_pu_o
);
    logic             single;
    logic [WIDTH-1:0] pu_gated;

    assign single = is_single_chip(mode_i);

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_pu
            // Pull-up only for an input pin with its control bit set.
            assign pu_gated[b] = pull_q_i[b] & ~dir_q_i[b];
        end
    endgenerate

    // Select register control or external bus control for the pads.
    always_comb begin
        if (single) begin
            pin_out_o = data_q_i;
            pin_oe_o  = dir_q_i;
            pin_pu_o  = pu_gated;
        end else begin
            pin_out_o = ext_data_i;
            pin_oe_o  = {WIDTH{ext_drive_i}};
            pin_pu_o  = '0;
        end
    end
endmodule

// File: rtl/gpio_port.sv
// Module: top of the mode-aware 8-bit GPIO port.
// Assumes: synchronous active-low reset; pad inputs are asynchronous.
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int            WIDTH       = 8,
    parameter int            AW          = 16,
    parameter int            SYNC_STAGES = 2,
    parameter logic [AW-1:0] DATA_ADDR   = 16'hFFB6,
    parameter logic [AW-1:0] DIR_ADDR    = 16'hFFB4,
    parameter logic [AW-1:0] PULL_ADDR   = 16'hFFAE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [AW-1:0]    bus_addr_i,
    input  logic             bus_wr_i,
    input  logic             bus_rd_i,
    input  logic [WIDTH-1:0] bus_wdata_i,
    output logic [WIDTH-1:0] bus_rdata_o,
    input  logic [WIDTH-1:0] pin_in_i,
    output logic [WIDTH-1:0] pin_out_o,
    output logic [WIDTH-1:0] pin_oe_o,
    output logic [WIDTH-1:0] pin_pu_o,
    input  logic [WIDTH-1:0] ext_data_i,
    input  logic             ext_drive_i,
    output logic [WIDTH-1:0] ext_pin_o
);
    reg_sel_e         sel;
    logic [WIDTH-1:0] data_q, dir_q, pull_q, pin_sync;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pin_in_i), .sync_o(pin_sync)
    );

    gpio_regfile #(
        .WIDTH(WIDTH), .AW(AW),
        .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR), .PULL_ADDR(PULL_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr_i), .wr_i(bus_wr_i),
        .wdata_i(bus_wdata_i), .sel_o(sel),
        .data_q_o(data_q), .dir_q_o(dir_q), .pull_q_o(pull_q)
    );

    gpio_readback #(.WIDTH(WIDTH)) u_rd (
        .rd_i(bus_rd_i), .sel_i(sel), .data_q_i(data_q), .dir_q_i(dir_q),
        .pull_q_i(pull_q), .pin_sync_i(pin_sync), .rdata_o(bus_rdata_o)
    );

    gpio_pin_mux #(.WIDTH(WIDTH)) u_mux (
        .mode_i(mode_i), .data_q_i(data_q), .dir_q_i(dir_q), .pull_q_i(pull_q),
        .ext_data_i(ext_data_i), .ext_drive_i(ext_drive_i),
        .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o), .pin_pu_o(pin_pu_o)
    );

    assign ext_pin_o = pin_sync;
endmodule

// File: rtl/gpio_port_chk.sv
// Module: assertion checker bound to gpio_port.
// Assumes: two synchronizer stages, as in the default configuration.
module gpio_port_chk #(
    parameter int            WIDTH     = 8,
    parameter int            AW        = 16,
    parameter logic [AW-1:0] DATA_ADDR = 16'hFFB6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_i,
    input logic [AW-1:0]    bus_addr_i,
    input logic             bus_wr_i,
    input logic             bus_rd_i,
    input logic [WIDTH-1:0] bus_wdata_i,
    input logic [WIDTH-1:0] bus_rdata_o,
    input logic [WIDTH-1:0] pin_in_i,
    input logic [WIDTH-1:0] pin_out_o,
    input logic [WIDTH-1:0] pin_oe_o,
    input logic [WIDTH-1:0] pin_pu_o,
    input logic [WIDTH-1:0] ext_data_i,
    input logic             ext_drive_i,
    input logic [WIDTH-1:0] ext_pin_o
);
    logic [1:0] settle_q;

    // Count edges since reset so history checks start on valid data.
    always_ff @(posedge clk) begin
        if (!rst_n)              settle_q <= '0;
        else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
    end

    AST_PULL_ONLY_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu_o & pin_oe_o) == '0); // R7

    AST_EXP_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'b11) |-> (pin_pu_o == '0)); // R8

    AST_EXP_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'b11) |-> (pin_oe_o == {WIDTH{ext_drive_i}})); // R8

    AST_EXP_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'b11) |-> (pin_out_o == ext_data_i)); // R8

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |-> (bus_rdata_o == '0)); // R10

    AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_q >= 2'd2) |-> (ext_pin_o == $past(pin_in_i, 2))); // R5

    AST_LATCH_TO_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == DATA_ADDR)
        |=> (mode_i != 2'b11 || pin_out_o == $past(bus_wdata_i))); // R2
endmodule

bind gpio_port gpio_port_chk #(
    .WIDTH(WIDTH), .AW(AW), .DATA_ADDR(DATA_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .bus_addr_i(bus_addr_i),
    .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .pin_in_i(pin_in_i), .pin_out_o(pin_out_o),
    .pin_oe_o(pin_oe_o), .pin_pu_o(pin_pu_o), .ext_data_i(ext_data_i),
    .ext_drive_i(ext_drive_i), .ext_pin_o(ext_pin_o)
);

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
    localparam logic [15:0] A_DATA = 16'hFFB6;
    localparam logic [15:0] A_DIR  = 16'hFFB4;
    localparam logic [15:0] A_PULL = 16'hFFAE;
    localparam logic [15:0] A_NONE = 16'hFFB0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b11;
    logic [15:0] addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [7:0]  wdata = '0, pins = '0, ext_data = '0;
    logic        ext_drive = 1'b0;
    logic [7:0]  rdata, pout, poe, ppu, epin;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // bench model
    logic [7:0] m_data = '0, m_dir = '0, m_pull = '0, m_s1 = '0, m_s2 = '0;

    always #10 clk = ~clk;   // 50 MHz

    gpio_port u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .bus_addr_i(addr),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .pin_in_i(pins), .pin_out_o(pout), .pin_oe_o(poe), .pin_pu_o(ppu),
        .ext_data_i(ext_data), .ext_drive_i(ext_drive), .ext_pin_o(epin)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rdata();
        if (!rd) return 8'h00;
        case (addr)
            A_DATA:  return (m_data & m_dir) | (m_s2 & ~m_dir);
            A_DIR:   return m_dir;
            A_PULL:  return m_pull;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rd_tag();
        case (addr)
            A_DATA:  return "R4";
            A_DIR:   return "R3";
            A_PULL:  return "R6";
            default: return "R10";
        endcase
    endfunction

    // Check all outputs before the edge, then advance one clock and the model.
    task automatic step(input string note);
        bit single;
        single = (mode == 2'b11);
        #2;
        check({rd_tag(), " read ", note}, rdata, exp_rdata());
        check(single ? "R2 pin_out" : "R8 pin_out", pout, single ? m_data : ext_data);
        check(single ? "R3 pin_oe" : "R8 pin_oe", poe, single ? m_dir : {8{ext_drive}});
        check(single ? "R7 pin_pu" : "R8 pin_pu", ppu, single ? (m_pull & ~m_dir) : 8'h00);
        check("R12 R5 ext_pin", epin, m_s2);
        @(posedge clk);
        if (wr) begin
            case (addr)
                A_DATA:  m_data = wdata;
                A_DIR:   m_dir  = wdata;
                A_PULL:  m_pull = wdata;
                default: ;
            endcase
        end
        m_s2 = m_s1;
        m_s1 = pins;
        @(negedge clk);
    endtask

    task automatic bus(input logic [15:0] a, input logic w, input logic r,
                       input logic [7:0] d, input string note);
        addr = a; wr = w; rd = r; wdata = d;
        step(note);
        wr = 1'b0; rd = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen at the ports
        #2;
        check("R1 pin_oe", poe, 8'h00);
        check("R1 pin_pu", ppu, 8'h00);
        check("R1 pin_out", pout, 8'h00);
        bus(A_DATA, 0, 1, 0, "R1");
        bus(A_DIR,  0, 1, 0, "R1");
        bus(A_PULL, 0, 1, 0, "R1");

        // R2 R3 R4: mixed direction read-back
        pins = 8'h3C;
        bus(A_DIR,  1, 0, 8'hF0, "R3");
        bus(A_DATA, 1, 0, 8'hA5, "R2");
        step("R5 settle");
        #2; check("R4 mixed read", u_rd_val(), 8'hAC);
        bus(A_DATA, 0, 1, 0, "R4");
        // R5: pin change visible after exactly two edges
        pins = 8'h03;
        bus(A_DATA, 0, 1, 0, "R5 edge0");
        bus(A_DATA, 0, 1, 0, "R5 edge1");
        bus(A_DATA, 0, 1, 0, "R5 edge2");
        // R6 R7: pull-ups gated by direction
        bus(A_PULL, 1, 0, 8'hFF, "R6");
        bus(A_PULL, 0, 1, 0, "R7");
        // R11: read and write in the same cycle
        bus(A_DIR, 1, 1, 8'h0F, "R11");
        bus(A_DIR, 0, 1, 0, "R11 after");
        // R10: undecoded access
        bus(A_NONE, 1, 1, 8'h77, "R10");
        bus(A_DATA, 0, 1, 0, "R10 unchanged");
        // R8 R9: expanded mode override and deferred writes
        mode = 2'b01; ext_data = 8'h96; ext_drive = 1'b1;
        bus(A_DATA, 1, 0, 8'h55, "R9");
        bus(A_DIR,  1, 0, 8'hFF, "R9");
        mode = 2'b00; ext_drive = 1'b0;
        bus(A_PULL, 1, 1, 8'h0F, "R8");
        mode = 2'b10;
        step("R8");
        mode = 2'b11;
        #2; check("R9 pin_out", pout, 8'h55);
        check("R9 pin_oe", poe, 8'hFF);
        step("R9");

        // random traffic
        for (int i = 0; i < 600; i++) begin
            logic [2:0] pick;
            pick = 3'($urandom_range(0, 4));
            addr = (pick == 0) ? A_DATA : (pick == 1) ? A_DIR :
                   (pick == 2) ? A_PULL : (pick == 3) ? A_DATA : 16'($urandom());
            wr = ($urandom_range(0, 2) == 0);
            rd = ($urandom_range(0, 1) == 0);
            wdata = 8'($urandom());
            mode = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 2)) : 2'b11;
            ext_data = 8'($urandom());
            ext_drive = 1'($urandom());
            if ($urandom_range(0, 2) == 0) pins = 8'($urandom());
            step("random");
        end
        wr = 1'b0; rd = 1'b0;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    function automatic logic [7:0] u_rd_val();
        return (8'hA5 & 8'hF0) | (m_s2 & 8'h0F);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule